// File: doc/BRIEF.md
# Mixed-Radix Timestamp Adder

This block adds two timestamps, each made of three fields: a whole-seconds count, a coarse count of reference-clock cycles inside the second, and a fractional count inside one coarse cycle. The fraction runs in binary radix (2^FRAC_W). The coarse count runs modulo a parameter that need not be a power of two (125 by default). The sum is brought back into canonical form. Fraction overflow carries into the coarse count. Coarse overflow or underflow then carries into or borrows from the seconds.

The first operand is always canonical. The second operand's coarse field is a two's-complement value that may lie anywhere from −(MOD−1) to MOD+9. This lets a caller add a signed offset in coarse units without normalizing it first. The normalizer therefore has to handle a carry of two as well as a borrow of one. A new operand pair may enter on every clock. Each result leaves exactly three cycles later with its own valid flag, and results stay in input order.

Top module: `tstamp_mradix_add`

## Requirements
- R1: The output fraction (bits FRAC_W-1:0 of `q_frac_o`) is the sum of the two input fractions modulo 2^FRAC_W. When that sum reaches 2^FRAC_W, one unit is carried into the coarse sum.
- R2: A coarse sum (including the fraction carry) of MOD up to 2·MOD−1 gives coarse = sum−MOD and carries one second. A coarse sum of 2·MOD or more gives coarse = sum−2·MOD and carries two seconds.
- R3: `b_coarse_i` is read as a two's-complement value in −(MOD−1)..MOD+9. A negative coarse sum gives coarse = sum+MOD and borrows one second. A sum of exactly 0 borrows nothing.
- R4: Every result is canonical, with `q_coarse_o` in 0..MOD−1. Its total value (frac + coarse·2^FRAC_W + sec·MOD·2^FRAC_W) equals the sum of the two operands' values.
- R5: The seconds arithmetic wraps modulo 2^SEC_W, and no overflow indication is produced.
- R6: `valid_o` rises exactly 3 clocks after the `valid_i` it belongs to. Back-to-back operands produce back-to-back results in the same order.
- R7: With `rst` high at a clock edge (synchronous, active high), every pipeline valid flag is cleared. `valid_o` is low after that edge, and any operand in flight is dropped.
- R8: A cycle with `valid_i` low produces a cycle with `valid_o` low 3 clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Operand pair present this cycle |
| a_sec_i | input | SEC_W | Operand A seconds |
| a_coarse_i | input | COARSE_W | Operand A coarse count, 0..MOD−1 |
| a_frac_i | input | FRAC_W | Operand A fraction |
| b_sec_i | input | SEC_W | Operand B seconds |
| b_coarse_i | input | COARSE_W | Operand B coarse count, two's complement |
| b_frac_i | input | FRAC_W | Operand B fraction |
| valid_o | output | 1 | Result present this cycle |
| q_sec_o | output | SEC_W | Result seconds, modulo 2^SEC_W |
| q_coarse_o | output | COARSE_W | Result coarse count, 0..MOD−1 |
| q_frac_o | output | FRAC_W | Result fraction |

## Verification
The bench builds the block with its default parameters: a 12-bit fraction, a 28-bit coarse field with modulus 125, and 32-bit seconds. With these values every normalization branch can be reached by directed operands: the fraction carry, a coarse carry of one and of two, the borrow, and the exact boundaries at 0, 125 and 250. Because the seconds field is 32 bits wide, a 64-bit reference can also drive the seconds across the 2^32 wrap in both directions, by carry and by borrow.

// File: rtl/tsadd_pkg.sv
package tsadd_pkg;

    localparam int unsigned DEF_FRAC_W     = 12;
    localparam int unsigned DEF_COARSE_W   = 28;
    localparam int unsigned DEF_SEC_W      = 32;
    localparam int unsigned DEF_COARSE_MOD = 125;

    // Seconds adjustment decided by the coarse normalizer
    typedef enum logic [1:0] {
        CY_BORROW = 2'd0,
        CY_NONE   = 2'd1,
        CY_PLUS1  = 2'd2,
        CY_PLUS2  = 2'd3
    } cy_e;

    function automatic logic signed [2:0] cy_delta(input cy_e c);
        case (c)
            CY_BORROW: cy_delta = -3'sd1;
            CY_PLUS1:  cy_delta = 3'sd1;
            CY_PLUS2:  cy_delta = 3'sd2;
            default:   cy_delta = 3'sd0;
        endcase
    endfunction

endpackage

// File: rtl/tsadd_frac_stage.sv
module tsadd_frac_stage #(
    parameter int unsigned FRAC_W   = tsadd_pkg::DEF_FRAC_W,
    parameter int unsigned COARSE_W = tsadd_pkg::DEF_COARSE_W,
    parameter int unsigned SEC_W    = tsadd_pkg::DEF_SEC_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                v_in,
    input  logic [SEC_W-1:0]    a_sec,
    input  logic [COARSE_W-1:0] a_coarse,
    input  logic [FRAC_W-1:0]   a_frac,
    input  logic [SEC_W-1:0]    b_sec,
    input  logic [COARSE_W-1:0] b_coarse,
    input  logic [FRAC_W-1:0]   b_frac,
    output logic                v_out,
    output logic [SEC_W-1:0]    a_sec_q,
    output logic [SEC_W-1:0]    b_sec_q,
    output logic [COARSE_W-1:0] a_coarse_q,
    output logic [COARSE_W-1:0] b_coarse_q,
    output logic [FRAC_W-1:0]   frac_q,
    output logic                fcy_q
);
    localparam int unsigned FSUM_W = FRAC_W + 1;

    logic [FSUM_W-1:0] fsum;

    // Radix is a power of two: the top bit of the sum is the carry
    assign fsum = {1'b0, a_frac} + {1'b0, b_frac};

    always_ff @(posedge clk) begin
        if (rst) begin
            v_out      <= 1'b0;
            a_sec_q    <= '0;
            b_sec_q    <= '0;
            a_coarse_q <= '0;
            b_coarse_q <= '0;
            frac_q     <= '0;
            fcy_q      <= 1'b0;
        end else begin
            v_out      <= v_in;
            a_sec_q    <= a_sec;
            b_sec_q    <= b_sec;
            a_coarse_q <= a_coarse;
            b_coarse_q <= b_coarse;
            frac_q     <= fsum[FRAC_W-1:0];
            fcy_q      <= fsum[FRAC_W];
        end
    end
endmodule

// File: rtl/tsadd_coarse_stage.sv
module tsadd_coarse_stage
    import tsadd_pkg::*;
#(
    parameter int unsigned FRAC_W     = DEF_FRAC_W,
    parameter int unsigned COARSE_W   = DEF_COARSE_W,
    parameter int unsigned SEC_W      = DEF_SEC_W,
    parameter int unsigned COARSE_MOD = DEF_COARSE_MOD
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                v_in,
    input  logic [SEC_W-1:0]    a_sec,
    input  logic [SEC_W-1:0]    b_sec,
    input  logic [COARSE_W-1:0] a_coarse,
    input  logic [COARSE_W-1:0] b_coarse,
    input  logic [FRAC_W-1:0]   frac,
    input  logic                fcy,
    output logic                v_out,
    output logic [SEC_W-1:0]    a_sec_q,
    output logic [SEC_W-1:0]    b_sec_q,
    output logic [COARSE_W-1:0] coarse_q,
    output logic [FRAC_W-1:0]   frac_q,
    output cy_e                 cy_q
);
    // Two guard bits: one for sign, one for sums up to about 3*MOD
    localparam int unsigned SW = COARSE_W + 2;
    localparam logic signed [SW-1:0] MOD1 = SW'(COARSE_MOD);
    localparam logic signed [SW-1:0] MOD2 = SW'(2 * COARSE_MOD);

    logic signed [SW-1:0]  csum;
    logic [COARSE_W-1:0]   coarse_d;
    cy_e                   cy_d;

    assign csum = $signed({2'b00, a_coarse})
                + $signed({{2{b_coarse[COARSE_W-1]}}, b_coarse})
                + $signed({{(SW-1){1'b0}}, fcy});

    always_comb begin
        if (csum[SW-1]) begin
            coarse_d = COARSE_W'(csum + MOD1);
            cy_d     = CY_BORROW;
        end else if (csum >= MOD2) begin
            coarse_d = COARSE_W'(csum - MOD2);
            cy_d     = CY_PLUS2;
        end else if (csum >= MOD1) begin
            coarse_d = COARSE_W'(csum - MOD1);
            cy_d     = CY_PLUS1;
        end else begin
            coarse_d = COARSE_W'(csum);
            cy_d     = CY_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_out    <= 1'b0;
            a_sec_q  <= '0;
            b_sec_q  <= '0;
            coarse_q <= '0;
            frac_q   <= '0;
            cy_q     <= CY_NONE;
        end else begin
            v_out    <= v_in;
            a_sec_q  <= a_sec;
            b_sec_q  <= b_sec;
            coarse_q <= coarse_d;
            frac_q   <= frac;
            cy_q     <= cy_d;
        end
    end
endmodule

// File: rtl/tsadd_sec_stage.sv
module tsadd_sec_stage
    import tsadd_pkg::*;
#(
    parameter int unsigned FRAC_W   = DEF_FRAC_W,
    parameter int unsigned COARSE_W = DEF_COARSE_W,
    parameter int unsigned SEC_W    = DEF_SEC_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                v_in,
    input  logic [SEC_W-1:0]    a_sec,
    input  logic [SEC_W-1:0]    b_sec,
    input  logic [COARSE_W-1:0] coarse,
    input  logic [FRAC_W-1:0]   frac,
    input  cy_e                 cy,
    output logic                v_out,
    output logic [SEC_W-1:0]    sec_q,
    output logic [COARSE_W-1:0] coarse_q,
    output logic [FRAC_W-1:0]   frac_q
);
    logic signed [2:0] delta;
    logic [SEC_W-1:0]  delta_ext;

    assign delta     = cy_delta(cy);
    assign delta_ext = {{(SEC_W-3){delta[2]}}, delta};

    always_ff @(posedge clk) begin
        if (rst) begin
            v_out    <= 1'b0;
            sec_q    <= '0;
            coarse_q <= '0;
            frac_q   <= '0;
        end else begin
            v_out    <= v_in;
            sec_q    <= a_sec + b_sec + delta_ext;   // wraps modulo 2^SEC_W
            coarse_q <= coarse;
            frac_q   <= frac;
        end
    end
endmodule

// File: rtl/tstamp_mradix_add.sv
module tstamp_mradix_add
    import tsadd_pkg::*;
#(
    parameter int unsigned FRAC_W     = DEF_FRAC_W,
    parameter int unsigned COARSE_W   = DEF_COARSE_W,
    parameter int unsigned SEC_W      = DEF_SEC_W,
    parameter int unsigned COARSE_MOD = DEF_COARSE_MOD
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                valid_i,
    input  logic [SEC_W-1:0]    a_sec_i,
    input  logic [COARSE_W-1:0] a_coarse_i,
    input  logic [FRAC_W-1:0]   a_frac_i,
    input  logic [SEC_W-1:0]    b_sec_i,
    input  logic [COARSE_W-1:0] b_coarse_i,
    input  logic [FRAC_W-1:0]   b_frac_i,
    output logic                valid_o,
    output logic [SEC_W-1:0]    q_sec_o,
    output logic [COARSE_W-1:0] q_coarse_o,
    output logic [FRAC_W-1:0]   q_frac_o
);
    // stage 1 -> stage 2
    logic                s1_v;
    logic [SEC_W-1:0]    s1_a_sec, s1_b_sec;
    logic [COARSE_W-1:0] s1_a_coarse, s1_b_coarse;
    logic [FRAC_W-1:0]   s1_frac;
    logic                s1_fcy;
    // stage 2 -> stage 3
    logic                s2_v;
    logic [SEC_W-1:0]    s2_a_sec, s2_b_sec;
    logic [COARSE_W-1:0] s2_coarse;
    logic [FRAC_W-1:0]   s2_frac;
    cy_e                 s2_cy;

    tsadd_frac_stage #(
        .FRAC_W(FRAC_W), .COARSE_W(COARSE_W), .SEC_W(SEC_W)
    ) u_frac (
        .clk(clk), .rst(rst), .v_in(valid_i),
        .a_sec(a_sec_i), .a_coarse(a_coarse_i), .a_frac(a_frac_i),
        .b_sec(b_sec_i), .b_coarse(b_coarse_i), .b_frac(b_frac_i),
        .v_out(s1_v), .a_sec_q(s1_a_sec), .b_sec_q(s1_b_sec),
        .a_coarse_q(s1_a_coarse), .b_coarse_q(s1_b_coarse),
        .frac_q(s1_frac), .fcy_q(s1_fcy)
    );

    tsadd_coarse_stage #(
        .FRAC_W(FRAC_W), .COARSE_W(COARSE_W), .SEC_W(SEC_W),
        .COARSE_MOD(COARSE_MOD)
    ) u_coarse (
        .clk(clk), .rst(rst), .v_in(s1_v),
        .a_sec(s1_a_sec), .b_sec(s1_b_sec),
        .a_coarse(s1_a_coarse), .b_coarse(s1_b_coarse),
        .frac(s1_frac), .fcy(s1_fcy),
        .v_out(s2_v), .a_sec_q(s2_a_sec), .b_sec_q(s2_b_sec),
        .coarse_q(s2_coarse), .frac_q(s2_frac), .cy_q(s2_cy)
    );

    tsadd_sec_stage #(
        .FRAC_W(FRAC_W), .COARSE_W(COARSE_W), .SEC_W(SEC_W)
    ) u_sec (
        .clk(clk), .rst(rst), .v_in(s2_v),
        .a_sec(s2_a_sec), .b_sec(s2_b_sec),
        .coarse(s2_coarse), .frac(s2_frac), .cy(s2_cy),
        .v_out(valid_o), .sec_q(q_sec_o),
        .coarse_q(q_coarse_o), .frac_q(q_frac_o)
    );
endmodule

// File: rtl/tsadd_chk.sv
module tsadd_chk #(
    parameter int unsigned FRAC_W     = 12,
    parameter int unsigned COARSE_W   = 28,
    parameter int unsigned SEC_W      = 32,
    parameter int unsigned COARSE_MOD = 125
) (
    input logic                clk,
    input logic                rst,
    input logic                valid_i,
    input logic [SEC_W-1:0]    a_sec_i,
    input logic [COARSE_W-1:0] a_coarse_i,
    input logic [FRAC_W-1:0]   a_frac_i,
    input logic [SEC_W-1:0]    b_sec_i,
    input logic [COARSE_W-1:0] b_coarse_i,
    input logic [FRAC_W-1:0]   b_frac_i,
    input logic                valid_o,
    input logic [SEC_W-1:0]    q_sec_o,
    input logic [COARSE_W-1:0] q_coarse_o,
    input logic [FRAC_W-1:0]   q_frac_o
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    function automatic longint subsec_sum(input logic [COARSE_W-1:0] ac,
                                          input logic [FRAC_W-1:0] af,
                                          input logic [COARSE_W-1:0] bc,
                                          input logic [FRAC_W-1:0] bf);
        longint s;
        s = longint'(af) + longint'(bf)
          + longint'(ac) * (longint'(1) << FRAC_W)
          + longint'($signed(bc)) * (longint'(1) << FRAC_W);
        return s;
    endfunction

    function automatic logic subsec_ok(input logic [COARSE_W-1:0] qc,
                                       input logic [FRAC_W-1:0] qf,
                                       input longint s);
        longint unit, r;
        unit = longint'(COARSE_MOD) * (longint'(1) << FRAC_W);
        r = s % unit;
        if (r < 0) r = r + unit;
        return r == longint'(qc) * (longint'(1) << FRAC_W) + longint'(qf);
    endfunction

    function automatic logic [SEC_W-1:0] sec_expect(input logic [SEC_W-1:0] as,
                                                    input logic [SEC_W-1:0] bs,
                                                    input longint s);
        longint unit, q;
        unit = longint'(COARSE_MOD) * (longint'(1) << FRAC_W);
        q = s / unit;
        if (s % unit < 0) q = q - 1;
        return as + bs + SEC_W'(q);
    endfunction

    // R7: reset empties the pipeline
    p_rst_clears_r7: assert property (@(posedge clk) rst |=> !valid_o);

    // R6 / R8: valid follows valid_i by exactly three clocks
    p_latency_r6: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (valid_o == $past(valid_i, 3)));

    // R4: coarse result canonical
    p_coarse_norm_r4: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (q_coarse_o < COARSE_W'(COARSE_MOD)));

    // R1: fraction wraps at the binary radix
    p_frac_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (valid_o && since_rst == 2'd3) |->
        (q_frac_o == FRAC_W'($past(a_frac_i, 3) + $past(b_frac_i, 3))));

    // R2 / R3 / R4: sub-second part equals the operand sum modulo one second
    p_subsec_r4: assert property (@(posedge clk) disable iff (rst)
        (valid_o && since_rst == 2'd3) |->
        subsec_ok(q_coarse_o, q_frac_o,
                  subsec_sum($past(a_coarse_i, 3), $past(a_frac_i, 3),
                             $past(b_coarse_i, 3), $past(b_frac_i, 3))));

    // R5: seconds gain the carry or borrow and wrap
    p_sec_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (valid_o && since_rst == 2'd3) |->
        (q_sec_o == sec_expect($past(a_sec_i, 3), $past(b_sec_i, 3),
                  subsec_sum($past(a_coarse_i, 3), $past(a_frac_i, 3),
                             $past(b_coarse_i, 3), $past(b_frac_i, 3)))));
endmodule

bind tstamp_mradix_add tsadd_chk #(
    .FRAC_W(FRAC_W), .COARSE_W(COARSE_W), .SEC_W(SEC_W), .COARSE_MOD(COARSE_MOD)
) u_chk (.*);

// File: tb/tstamp_mradix_add_tb.sv
module tstamp_mradix_add_tb;
    localparam int CLK_P    = 10;
    localparam int FRAC_W   = 12;
    localparam int COARSE_W = 28;
    localparam int SEC_W    = 32;
    localparam int MOD      = 125;
    localparam longint UNIT = longint'(MOD) * 4096;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic valid_i = 1'b0;
    logic [SEC_W-1:0]    a_sec_i = '0, b_sec_i = '0;
    logic [COARSE_W-1:0] a_coarse_i = '0, b_coarse_i = '0;
    logic [FRAC_W-1:0]   a_frac_i = '0, b_frac_i = '0;
    logic                valid_o;
    logic [SEC_W-1:0]    q_sec_o;
    logic [COARSE_W-1:0] q_coarse_o;
    logic [FRAC_W-1:0]   q_frac_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    string cur_tag = "R4";

    always #(CLK_P/2) clk = ~clk;

    tstamp_mradix_add u_dut (
        .clk(clk), .rst(rst), .valid_i(valid_i),
        .a_sec_i(a_sec_i), .a_coarse_i(a_coarse_i), .a_frac_i(a_frac_i),
        .b_sec_i(b_sec_i), .b_coarse_i(b_coarse_i), .b_frac_i(b_frac_i),
        .valid_o(valid_o), .q_sec_o(q_sec_o),
        .q_coarse_o(q_coarse_o), .q_frac_o(q_frac_o)
    );

    typedef struct {
        bit          v;
        longint      sec;
        longint      coarse;
        longint      frac;
        string       tag;
    } exp_t;

    exp_t mp[3];

    initial begin
        for (int k = 0; k < 3; k++) begin
            mp[k].v = 0; mp[k].sec = 0; mp[k].coarse = 0; mp[k].frac = 0;
            mp[k].tag = "R7";
        end
    end

    // Reference: flatten both operands into one integer and split again
    function automatic exp_t model();
        exp_t e;
        longint t;
        t = longint'(a_frac_i) + longint'(a_coarse_i) * 4096 + longint'(a_sec_i) * UNIT
          + longint'(b_frac_i) + longint'($signed(b_coarse_i)) * 4096
          + longint'(b_sec_i) * UNIT
          + (longint'(1) << 32) * UNIT;        // keeps t positive
        e.v      = valid_i;
        e.sec    = (t / UNIT) % (longint'(1) << 32);
        e.coarse = (t % UNIT) / 4096;
        e.frac   = (t % UNIT) % 4096;
        e.tag    = valid_i ? cur_tag : "R8";
        return e;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 3; k++) begin mp[k].v = 0; mp[k].tag = "R7"; end
        end else begin
            mp[2] = mp[1];
            mp[1] = mp[0];
            mp[0] = model();
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            total++;
            if (valid_o !== mp[2].v) begin
                bad++;
                $display("FAIL %s valid: actual=%0b expected=%0b", mp[2].tag, valid_o, mp[2].v);
            end
            if (mp[2].v) begin
                total++;
                if (longint'(q_frac_o) != mp[2].frac || longint'(q_coarse_o) != mp[2].coarse
                    || longint'(q_sec_o) != mp[2].sec) begin
                    bad++;
                    $display("FAIL %s result: actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                             mp[2].tag, q_sec_o, q_coarse_o, q_frac_o,
                             mp[2].sec, mp[2].coarse, mp[2].frac);
                end
            end
        end
    end

    task automatic put(input bit v, input string tag,
                       input longint as, input longint ac, input longint af,
                       input longint bs, input longint bc, input longint bf);
        @(negedge clk);
        cur_tag    = tag;
        valid_i    = v;
        a_sec_i    = SEC_W'(as);
        a_coarse_i = COARSE_W'(ac);
        a_frac_i   = FRAC_W'(af);
        b_sec_i    = SEC_W'(bs);
        b_coarse_i = COARSE_W'(bc);
        b_frac_i   = FRAC_W'(bf);
    endtask

    task automatic put_rand(input bit v);
        put(v, "R4", $urandom, $urandom_range(0, MOD-1), $urandom_range(0, 4095),
            $urandom, longint'($urandom_range(0, 2*MOD+8)) - (MOD-1), $urandom_range(0, 4095));
    endtask

    initial begin
        void'($urandom(7));
        repeat (3) @(negedge clk);
        rst = 1'b0;                                    // R7 reset state seen by monitor
        put(0, "R7", 0, 0, 0, 0, 0, 0);
        // R1: fraction carries
        put(1, "R1", 10, 3, 4095, 2, 4, 1);
        put(1, "R1", 10, 3, 4095, 2, 4, 4095);
        // R2: carry of one, exact boundaries, carry of two
        put(1, "R2", 1, 100, 5, 1, 30, 6);
        put(1, "R2", 1, 100, 0, 1, 25, 0);
        put(1, "R2", 1, 124, 0, 1, 126, 0);
        put(1, "R2", 1, 124, 4095, 1, 134, 1);
        put(1, "R2", 1, 124, 4000, 1, 125, 95);
        // R3: borrows and the zero boundary
        put(1, "R3", 7, 0, 0, 7, -124, 0);
        put(1, "R3", 7, 0, 0, 7, -1, 0);
        put(1, "R3", 7, 5, 9, 7, -5, 9);
        put(1, "R3", 7, 0, 4095, 7, -1, 1);
        // R5: seconds wrap both ways
        put(1, "R5", 32'hFFFF_FFFF, 124, 0, 0, 1, 0);
        put(1, "R5", 0, 0, 0, 0, -3, 0);
        put(1, "R5", 32'hFFFF_FFFF, 124, 4095, 32'hFFFF_FFFF, 134, 4095);
        // R6: back-to-back stream
        for (int i = 0; i < 300; i++) put_rand(1);
        // R8: bubbles
        for (int i = 0; i < 300; i++) put_rand($urandom_range(0, 1) == 1);
        // R7: reset with pipeline full
        put_rand(1); put_rand(1);
        @(negedge clk); rst = 1'b1; valid_i = 1'b1;
        @(negedge clk); rst = 1'b0; valid_i = 1'b0; cur_tag = "R7";
        put(0, "R7", 0, 0, 0, 0, 0, 0);
        put(0, "R7", 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 50; i++) put_rand(1);
        put(0, "R8", 0, 0, 0, 0, 0, 0);
        repeat (6) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule